// File: doc/BRIEF.md
# Latched Free-Running Interval Timer

This block is a 16-bit down-counter paired with a separate 16-bit reload latch. Software reaches it through four byte-wide registers (two counter bytes and two latch bytes). The counter steps down by one on every clock cycle in which the tick-enable input is high. Once it has passed zero it shows the all-ones value for one tick. In continuous mode it then reloads from the latch, so every period after the first lasts latch+2 ticks. In one-shot mode it keeps wrapping downward without reloading, and it signals only the first expiry after each load.

On an expiry the block raises a one-cycle pulse for the interrupt controller and sets a sticky timer flag. The flag is cleared by the controller's clear strobe, by reading the counter low byte, and by writing either high byte. The mode is selected by a single input. The system drives it from bit 6 of an auxiliary control byte held outside this block, where 1 selects continuous operation.

Top module: `ivl_timer`

## Requirements
- R1: After reset the latch and the counter both hold 0xFFFF, the flag is 0 and the pulse output is 0.
- R2: A write to address 0 (counter low) or address 2 (latch low) changes only the low latch byte. The counter and the high latch byte keep their values.
- R3: A write to address 3 (latch high) stores the high latch byte and clears the flag. It does not load the counter.
- R4: A write to address 1 (counter high) stores the high latch byte, clears the flag and loads the whole new latch value into the counter on the same edge. This load takes priority over a tick in the same cycle.
- R5: `bus_rdata` shows the addressed byte: address 0 the counter low byte, 1 the counter high byte, 2 the latch low byte, 3 the latch high byte. A read strobe at address 0 clears the flag. A read strobe at address 1 leaves the flag unchanged.
- R6: With `aux_cont`=1 the counter runs down to 0, shows 0xFFFF for one tick and then reloads from the latch, giving a period of latch+2 ticks. Each time the counter is counted to 0, `irq_pulse` is high for exactly one cycle, in the cycle after that tick, together with the flag being set.
- R7: With `aux_cont`=0 the counter does not reload after 0xFFFF but keeps decrementing. Only the first arrival at 0 after a counter-high write produces a pulse.
- R8: A high `flag_clr` clears the flag on the next edge.
- R9: When an expiry and any flag-clear source fall in the same cycle, the flag ends up set and the pulse is still produced.
- R10: In a cycle with `tick_en` low and no counter-high write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable; one decrement per high cycle |
| aux_cont | input | 1 | Mode: 1 continuous reload, 0 one-shot |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 2 | Register select 0..3 |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Addressed register byte (combinational) |
| flag_clr | input | 1 | Flag clear strobe from the interrupt controller |
| irq_pulse | output | 1 | One-cycle expiry pulse |
| expired | output | 1 | Sticky timer flag |

## Verification
An expiry can coincide with a clearing of the flag, either by the `flag_clr` strobe or by a counter-low read. The bench sets the counter to 1 and then raises `tick_en` together with the clear source in one cycle. It expects the flag to remain set and one pulse to be counted. Loading and counting can also collide: the bench issues a counter-high write in a tick cycle and expects the counter to hold the latch value, not a decremented one.

// File: rtl/ivl_timer_pkg.sv
// Package: shared register selects and decoded command bundle for the
// interval timer. Assumes a fixed four-register byte map.
package ivl_timer_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_LAT_LO = 2'd2,
        SEL_LAT_HI = 2'd3
    } tmr_sel_e;

    typedef struct packed {
        logic lat_lo_wr;   // low latch byte written
        logic lat_hi_wr;   // high latch byte written
        logic cnt_load;    // counter loaded from latch
        logic flag_clr;    // access-side flag clear
    } tmr_cmd_t;
endpackage

// File: rtl/ivl_timer_decode.sv
// Module: turns a register access into the set of side effects it has.
// Assumes read and write strobes are single-cycle and not both high.
module ivl_timer_decode
    import ivl_timer_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output tmr_cmd_t          cmd
);
    // Map each address to its write and read side effects.
    always_comb begin
        cmd = '0;
        case (tmr_sel_e'(addr))
            SEL_CNT_LO: begin
                cmd.lat_lo_wr = wr_en;
                cmd.flag_clr  = rd_en;
            end
            SEL_CNT_HI: begin
                cmd.lat_hi_wr = wr_en;
                cmd.cnt_load  = wr_en;
                cmd.flag_clr  = wr_en;
            end
            SEL_LAT_LO: begin
                cmd.lat_lo_wr = wr_en;
            end
            SEL_LAT_HI: begin
                cmd.lat_hi_wr = wr_en;
                cmd.flag_clr  = wr_en;
            end
            default: cmd = '0;
        endcase
    end
endmodule

// File: rtl/ivl_timer_latch.sv
// Module: reload latch built from byte lanes, each written independently.
// Assumes the latch width is a whole number of data bytes.
module ivl_timer_latch #(
    parameter int DATA_W = 8,
    parameter int LANES  = 2,
    localparam int LAT_W = DATA_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [LAT_W-1:0]  latch_q
);
    logic [DATA_W-1:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Hold one latch byte; all ones out of reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= '1;
            else if (lane_we[g])
                lane_q[g] <= wdata;
        end
        assign latch_q[g*DATA_W +: DATA_W] = lane_q[g];
    end
endmodule

// File: rtl/ivl_timer_core.sv
// Module: down-counter with a one-tick all-ones phase after zero, optional
// reload from the latch, and one-shot arming. Assumes load beats tick.
module ivl_timer_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cont_mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] latch_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire_evt
);
    logic             under_q;
    logic             armed_q;
    logic [CNT_W-1:0] step_val;
    logic             hit_zero;

    // Value the counter takes on a tick: reload after the all-ones phase.
    always_comb begin
        step_val = cnt_q - CNT_W'(1);
        if (under_q && cont_mode)
            step_val = latch_q;
    end

    assign hit_zero   = tick_en && !load && (step_val == '0);
    assign expire_evt = hit_zero && (cont_mode || armed_q);

    // Counter, underflow phase marker and one-shot arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '1;
            under_q <= 1'b0;
            armed_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            under_q <= 1'b0;
            armed_q <= 1'b1;
        end else if (tick_en) begin
            cnt_q   <= step_val;
            under_q <= (cnt_q == '0);
            if (hit_zero && !cont_mode)
                armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ivl_timer_flag.sv
// Module: sticky expiry flag and registered one-cycle pulse.
// Assumes a set request outranks any clear in the same cycle.
module ivl_timer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic expired,
    output logic irq_pulse
);
    // Flag state: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            expired <= 1'b0;
        else if (set_req)
            expired <= 1'b1;
        else if (clr_req)
            expired <= 1'b0;
    end

    // Pulse register: high for the cycle after an expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_pulse <= 1'b0;
        else
            irq_pulse <= set_req;
    end
endmodule

// File: rtl/ivl_timer.sv
// Module: top of the latched interval timer. Connects access decode,
// latch, counter core and flag, and drives the read data mux.
// Assumes byte-wide accesses and a counter of two data bytes.
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              aux_cont,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              flag_clr,
    output logic              irq_pulse,
    output logic              expired
);
    localparam int LANES = 2;
    localparam int CNT_W = DATA_W * LANES;

    tmr_cmd_t         cmd;
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             expire_evt;

    ivl_timer_decode u_dec (
        .wr_en (bus_wr),
        .rd_en (bus_rd),
        .addr  (bus_addr),
        .cmd   (cmd)
    );

    ivl_timer_latch #(.DATA_W(DATA_W), .LANES(LANES)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we ({cmd.lat_hi_wr, cmd.lat_lo_wr}),
        .wdata   (bus_wdata),
        .latch_q (latch_q)
    );

    // The counter loads the latch as it will be after this write.
    assign load_val = {bus_wdata, latch_q[DATA_W-1:0]};

    ivl_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .cont_mode  (aux_cont),
        .load       (cmd.cnt_load),
        .load_val   (load_val),
        .latch_q    (latch_q),
        .cnt_q      (cnt_q),
        .expire_evt (expire_evt)
    );

    ivl_timer_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (expire_evt),
        .clr_req   (cmd.flag_clr | flag_clr),
        .expired   (expired),
        .irq_pulse (irq_pulse)
    );

    // Read data mux: addressed byte, independent of the read strobe.
    always_comb begin
        case (tmr_sel_e'(bus_addr))
            SEL_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
            SEL_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
            SEL_LAT_LO: bus_rdata = latch_q[DATA_W-1:0];
            SEL_LAT_HI: bus_rdata = latch_q[CNT_W-1:DATA_W];
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ivl_timer_chk.sv
// Checker: temporal properties of the interval timer, bound to its top.
module ivl_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic             flag_clr,
    input logic             irq_pulse,
    input logic             expired,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] latch_q,
    input logic             expire_evt
);
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_pulse_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (cnt_q == '0 && expired));

    p_load_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (cnt_q == latch_q && !expired));

    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(bus_wr && bus_addr == 2'd1)) |=> $stable(cnt_q));

    p_hi_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 2'd1 && expired && !flag_clr)
        |=> expired);

    p_strobe_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !expire_evt) |=> !expired);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_evt |=> (expired && irq_pulse));
endmodule

bind ivl_timer ivl_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .flag_clr   (flag_clr),
    .irq_pulse  (irq_pulse),
    .expired    (expired),
    .cnt_q      (cnt_q),
    .latch_q    (latch_q),
    .expire_evt (expire_evt)
);

// File: tb/ivl_timer_tb_top.sv
module ivl_timer_tb_top;
    localparam int CLK_P = 10;
    localparam int WDOG  = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       aux_cont = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       flag_clr = 1'b0;
    logic       irq_pulse;
    logic       expired;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    int base;

    typedef struct {
        logic [1:0] a;
        logic [7:0] d;
        string      req;
    } rd_item_t;
    rd_item_t sb_q[$];
    rd_item_t it;

    always #(CLK_P/2) clk = ~clk;

    ivl_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .aux_cont  (aux_cont),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .flag_clr  (flag_clr),
        .irq_pulse (irq_pulse),
        .expired   (expired)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items on reads and counts pulses.
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (bus_rd) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "SB-empty", bus_rdata, 0);
            end else begin
                it = sb_q.pop_front();
                chk(bus_rdata == it.d, it.req, bus_rdata, it.d);
            end
        end
        if (irq_pulse) pulse_cnt++;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] d, input string req);
        rd_item_t x;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        x.a = a; x.d = d; x.req = req;
        sb_q.push_back(x);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic settle;
        #(CLK_P/4 + 1);
    endtask

    task automatic chk_flag(input logic exp, input string req);
        settle();
        chk(expired == exp, req, expired, exp);
    endtask

    task automatic chk_pulses(input int exp, input string req);
        settle();
        chk(pulse_cnt - base == exp, req, pulse_cnt - base, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        settle();
        chk(expired == 1'b0 && irq_pulse == 1'b0, "R1 flag/pulse", {expired, irq_pulse}, 0);
        rd(2'd0, 8'hFF, "R1 cnt lo");
        rd(2'd1, 8'hFF, "R1 cnt hi");
        rd(2'd2, 8'hFF, "R1 lat lo");
        rd(2'd3, 8'hFF, "R1 lat hi");
        // R10 no tick: counter holds
        repeat (5) @(negedge clk);
        rd(2'd0, 8'hFF, "R10 hold");
        // R2 low byte writes touch only the latch low byte
        wr(2'd0, 8'h05);
        rd(2'd2, 8'h05, "R2 lat lo");
        rd(2'd3, 8'hFF, "R2 lat hi");
        rd(2'd0, 8'hFF, "R2 cnt unchanged");
        // R3 latch high: no counter load
        wr(2'd3, 8'h00);
        rd(2'd3, 8'h00, "R3 lat hi");
        rd(2'd1, 8'hFF, "R3 cnt hi unchanged");
        // R4 counter-high load, continuous mode
        aux_cont = 1'b1;
        wr(2'd1, 8'h00);
        rd(2'd0, 8'h05, "R4 cnt lo loaded");
        rd(2'd1, 8'h00, "R4 cnt hi loaded");
        chk_flag(1'b0, "R4 flag clear");
        // R6 count to zero and pulse
        base = pulse_cnt;
        run_ticks(5);
        chk_pulses(1, "R6 one pulse at zero");
        chk_flag(1'b1, "R6 flag set");
        // R5 hi read keeps flag, lo read clears it
        rd(2'd1, 8'h00, "R5 cnt hi at zero");
        chk_flag(1'b1, "R5 hi read keeps flag");
        rd(2'd0, 8'h00, "R5 cnt lo at zero");
        chk_flag(1'b0, "R5 lo read clears flag");
        // R6 all-ones phase then reload
        run_ticks(1);
        rd(2'd0, 8'hFF, "R6 ffff lo");
        rd(2'd1, 8'hFF, "R6 ffff hi");
        run_ticks(1);
        rd(2'd0, 8'h05, "R6 reload");
        base = pulse_cnt;
        run_ticks(14);
        chk_pulses(2, "R6 period latch+2");
        rd(2'd0, 8'h05, "R6 phase after two periods");
        // R8 flag clear strobe
        run_ticks(5);
        chk_flag(1'b1, "R8 flag set before strobe");
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk_flag(1'b0, "R8 strobe clears");
        // R3 latch-high write clears flag without load
        run_ticks(7);
        chk_flag(1'b1, "R3 flag set");
        wr(2'd3, 8'h00);
        chk_flag(1'b0, "R3 latch hi clears flag");
        rd(2'd0, 8'h00, "R3 counter not loaded");
        // R9 expiry with strobe in the same cycle
        run_ticks(6);
        rd(2'd0, 8'h01, "R9 setup at one");
        base = pulse_cnt;
        @(negedge clk); tick_en = 1'b1; flag_clr = 1'b1;
        @(negedge clk); tick_en = 1'b0; flag_clr = 1'b0;
        chk_flag(1'b1, "R9 set wins over strobe");
        chk_pulses(1, "R9 pulse kept");
        // R9 expiry with counter-low read in the same cycle
        run_ticks(6);
        begin
            rd_item_t x;
            @(negedge clk);
            tick_en = 1'b1; bus_rd = 1'b1; bus_addr = 2'd0;
            x.a = 2'd0; x.d = 8'h01; x.req = "R9 read during expiry";
            sb_q.push_back(x);
            @(negedge clk);
            tick_en = 1'b0; bus_rd = 1'b0;
        end
        chk_flag(1'b1, "R9 set wins over read clear");
        // R4 load beats tick in the same cycle
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h00;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        chk_flag(1'b0, "R4 write clears flag");
        rd(2'd0, 8'h05, "R4 load beats tick");
        // R7 one-shot
        aux_cont = 1'b0;
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h00);
        base = pulse_cnt;
        run_ticks(3);
        chk_pulses(1, "R7 first expiry pulses");
        run_ticks(1);
        rd(2'd1, 8'hFF, "R7 ffff hi");
        rd(2'd0, 8'hFF, "R7 ffff lo");
        run_ticks(1);
        rd(2'd0, 8'hFE, "R7 no reload");
        base = pulse_cnt;
        run_ticks(65534);
        chk_pulses(0, "R7 second zero silent");
        rd(2'd0, 8'h00, "R7 wrapped to zero lo");
        rd(2'd1, 8'h00, "R7 wrapped to zero hi");
        chk_flag(1'b0, "R7 flag not set again");
        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "SB drained", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule